// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Generator

This block produces several pulse-width-modulated outputs from one shared timebase. A single counter runs from zero up to a programmable modulus and wraps back to zero. Every channel compares that counter against its own duty value and drives its output active while the counter is below the duty. A per-channel polarity bit selects whether the active level is high or low. The modulus is common to all channels, so all outputs share one frequency. The counter advances once every 2^PRESCALE_EXP clock cycles.

Software talks to the block through a one-cycle command port. A command selects an operation, a channel index, a polarity bit and a data word. Every command gets a response code one cycle later. Duty and polarity writes land in shadow registers and only reach the active compare registers on a reload trigger. A reload trigger is either an explicit reload command or any accepted period command. A period command that changes the modulus also clears the counter and sets it running.

A neighbouring capture unit reports its armed interrupts on `cap_arm`. While any of them is set, the modulus cannot be changed. A duty write is refused while the odd member of the target channel's pair is armed.

Top module: `pwm_edge_gen`

## Requirements
- R1: A period command (op 0) carrying data zero returns code 1 (unsupported) and leaves the modulus and every output unchanged.
- R2: A duty command (op 1) with a channel index at or above NUM_CH returns code 1.
- R3: A channel with its polarity bit at 1 drives its output low while the counter is below its duty, and high otherwise. With the bit at 0 the sense is reversed.
- R4: One modulus governs all channels. Over any window of (mod+1)·2^PRESCALE_EXP cycles, each enabled channel's active-cycle count depends only on its own duty and that shared modulus.
- R5: An accepted period command with a new nonzero modulus performs four actions: it loads the modulus, clears the counter to zero, copies all shadow duty/polarity/enable state to the active registers, and sets the counter running. The output reflects counter value 0 from the second clock edge after the command.
- R6: A duty command only updates shadow state. The outputs change only after a reload command (op 2) or an accepted period command.
- R7: After reset every output is 0, no channel is enabled, the counter is stopped, and `resp_valid` is low. Each command produces `resp_valid` exactly one cycle later.
- R8: Busy handling uses code 2. A period command with a new modulus returns code 2 while any `cap_arm` bit is set. A duty command for channel c returns code 2 while `cap_arm[c|1]` is set. A duty command for a channel of another pair, or a period command repeating the current modulus, is accepted with code 0.
- R9: Edge-aligned compare: the counter takes values 0..mod. A channel is active while counter < duty. A duty at or above the modulus is active on every cycle, and a duty of 0 is never active.
- R10: A rate command (op 4) returns code 0 with `resp_data` = CLK_HZ >> PRESCALE_EXP.
- R11: A run command (op 3) with data bit 0 at 0 freezes the counter and prescaler, so the outputs hold. With data bit 0 at 1 it resumes counting.
- R12: Opcodes 5, 6 and 7 return code 1 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation: 0 period, 1 duty, 2 reload, 3 run, 4 rate |
| cmd_ch | input | CH_IDX_W | Channel index for duty commands |
| cmd_inv | input | 1 | Polarity for duty commands (1 = active low) |
| cmd_data | input | CNT_W | Modulus, duty value, or run flag in bit 0 |
| cap_arm | input | NUM_CH | Capture interrupt enables from the capture unit |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 0 ok, 1 unsupported, 2 busy |
| resp_data | output | RATE_W | Tick rate for rate commands, else 0 |
| pwm_out | output | NUM_CH | PWM outputs |

## Verification
Every cycle, the assertions check four things. First, each command is answered on the next cycle. Second, zero periods, out-of-range channels and undefined opcodes are refused. Third, a modulus change under an armed capture is answered busy and leaves the modulus alone. Fourth, the counter stays within 0..mod and stays frozen while stopped. Some behaviour shows only in the bench's scenarios, because it concerns whole waveforms rather than single cycles. That covers the duty-to-output mapping over a full period, polarity inversion, and the shadow-until-reload behaviour. It also covers the counter restart seen at an output and the shared-period effect across channels.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
    typedef enum logic [2:0] {
        OP_PERIOD = 3'd0,
        OP_DUTY   = 3'd1,
        OP_RELOAD = 3'd2,
        OP_RUN    = 3'd3,
        OP_RATE   = 3'd4
    } pwm_op_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_UNSUP = 2'd1,
        RSP_BUSY  = 2'd2
    } pwm_rsp_e;
endpackage

// File: rtl/pwm_cmd_check.sv
module pwm_cmd_check
    import pwm_edge_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = 4,
    parameter int CNT_W    = 16
) (
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [CH_IDX_W-1:0] cmd_ch,
    input  logic [CNT_W-1:0]    cmd_data,
    input  logic [NUM_CH-1:0]   cap_arm,
    input  logic [CNT_W-1:0]    cur_mod,
    output logic [1:0]          rsp_code,
    output logic                acc_period_chg,
    output logic                acc_period_same,
    output logic                acc_duty,
    output logic                acc_reload,
    output logic                acc_run,
    output logic                acc_rate
);
    logic                ch_ok;
    logic                pair_busy;
    logic [CH_IDX_W-1:0] odd_idx;

    always_comb begin
        ch_ok     = (cmd_ch < CH_IDX_W'(NUM_CH));
        odd_idx   = cmd_ch | CH_IDX_W'(1);
        pair_busy = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (CH_IDX_W'(i) == odd_idx) pair_busy = cap_arm[i];
        end
    end

    always_comb begin
        rsp_code        = RSP_OK;
        acc_period_chg  = 1'b0;
        acc_period_same = 1'b0;
        acc_duty        = 1'b0;
        acc_reload      = 1'b0;
        acc_run         = 1'b0;
        acc_rate        = 1'b0;
        if (cmd_valid) begin
            case (pwm_op_e'(cmd_op))
                OP_PERIOD: begin
                    if (cmd_data == '0)           rsp_code = RSP_UNSUP;
                    else if (cmd_data == cur_mod) acc_period_same = 1'b1;
                    else if (|cap_arm)            rsp_code = RSP_BUSY;
                    else                          acc_period_chg = 1'b1;
                end
                OP_DUTY: begin
                    if (!ch_ok)         rsp_code = RSP_UNSUP;
                    else if (pair_busy) rsp_code = RSP_BUSY;
                    else                acc_duty = 1'b1;
                end
                OP_RELOAD: acc_reload = 1'b1;
                OP_RUN:    acc_run    = 1'b1;
                OP_RATE:   acc_rate   = 1'b1;
                default:   rsp_code   = RSP_UNSUP;
            endcase
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W        = 16,
    parameter int PRESCALE_EXP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] mod,
    output logic [CNT_W-1:0] cnt
);
    localparam int PW = (PRESCALE_EXP > 0) ? PRESCALE_EXP : 1;

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      tick;

    generate
        if (PRESCALE_EXP == 0) begin : g_no_div
            assign tick = 1'b1;
        end else begin : g_div
            assign tick = &st_q.pre;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else if (run) begin
            st_d.pre = st_q.pre + PW'(1);
            if (tick) st_d.cnt = (st_q.cnt >= mod) ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mod,
    input  logic [CNT_W-1:0] duty,
    input  logic             inv,
    input  logic             en,
    output logic             pwm
);
    logic active;
    logic pwm_d, pwm_q;

    always_comb begin
        active = (duty >= mod) || (cnt < duty);
        pwm_d  = en ? (active ^ inv) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int CH_IDX_W     = 4,
    parameter int CNT_W        = 16,
    parameter int RATE_W       = 32,
    parameter int CLK_HZ       = 50_000_000,
    parameter int PRESCALE_EXP = 0,
    parameter int MOD_RESET    = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [CH_IDX_W-1:0] cmd_ch,
    input  logic                cmd_inv,
    input  logic [CNT_W-1:0]    cmd_data,
    input  logic [NUM_CH-1:0]   cap_arm,
    output logic                resp_valid,
    output logic [1:0]          resp_code,
    output logic [RATE_W-1:0]   resp_data,
    output logic [NUM_CH-1:0]   pwm_out
);
    localparam logic [RATE_W-1:0] TICK_RATE = RATE_W'(CLK_HZ >> PRESCALE_EXP);

    typedef struct packed {
        logic [CNT_W-1:0]             mod;
        logic                         run;
        logic [NUM_CH-1:0][CNT_W-1:0] sh_duty;
        logic [NUM_CH-1:0][CNT_W-1:0] act_duty;
        logic [NUM_CH-1:0]            sh_inv;
        logic [NUM_CH-1:0]            act_inv;
        logic [NUM_CH-1:0]            sh_en;
        logic [NUM_CH-1:0]            act_en;
        logic                         rsp_v;
        logic [1:0]                   rsp_code;
        logic [RATE_W-1:0]            rsp_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]       chk_code;
    logic             acc_period_chg, acc_period_same, acc_duty;
    logic             acc_reload, acc_run, acc_rate;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cur_mod;
    logic             run_now;

    assign cur_mod = r_q.mod;
    assign run_now = r_q.run;

    pwm_cmd_check #(
        .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W), .CNT_W(CNT_W)
    ) u_check (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
        .cmd_data(cmd_data), .cap_arm(cap_arm), .cur_mod(cur_mod),
        .rsp_code(chk_code), .acc_period_chg(acc_period_chg),
        .acc_period_same(acc_period_same), .acc_duty(acc_duty),
        .acc_reload(acc_reload), .acc_run(acc_run), .acc_rate(acc_rate)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rsp_v    = cmd_valid;
        r_d.rsp_code = chk_code;
        r_d.rsp_data = acc_rate ? TICK_RATE : '0;
        if (acc_duty) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (CH_IDX_W'(i) == cmd_ch) begin
                    r_d.sh_duty[i] = cmd_data;
                    r_d.sh_inv[i]  = cmd_inv;
                    r_d.sh_en[i]   = 1'b1;
                end
            end
        end
        if (acc_reload || acc_period_chg || acc_period_same) begin
            r_d.act_duty = r_q.sh_duty;
            r_d.act_inv  = r_q.sh_inv;
            r_d.act_en   = r_q.sh_en;
        end
        if (acc_period_chg) begin
            r_d.mod = cmd_data;
            r_d.run = 1'b1;
        end
        if (acc_run) r_d.run = cmd_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.mod <= CNT_W'(MOD_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    pwm_timebase #(
        .CNT_W(CNT_W), .PRESCALE_EXP(PRESCALE_EXP)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .run(r_q.run), .restart(acc_period_chg),
        .mod(r_q.mod), .cnt(cnt_w)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pwm_channel #(.CNT_W(CNT_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .mod(r_q.mod),
                .duty(r_q.act_duty[g]), .inv(r_q.act_inv[g]),
                .en(r_q.act_en[g]), .pwm(pwm_out[g])
            );
        end
    endgenerate

    assign resp_valid = r_q.rsp_v;
    assign resp_code  = r_q.rsp_code;
    assign resp_data  = r_q.rsp_data;
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = 4,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [2:0]          cmd_op,
    input logic [CH_IDX_W-1:0] cmd_ch,
    input logic [CNT_W-1:0]    cmd_data,
    input logic [NUM_CH-1:0]   cap_arm,
    input logic                resp_valid,
    input logic [1:0]          resp_code,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    mod,
    input logic                run
);
    p_resp_follows_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> resp_valid);

    p_no_spurious_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !resp_valid);

    p_zero_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && cmd_data == '0) |=> (resp_code == 2'd1 && $stable(mod)));

    p_bad_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && cmd_ch >= CH_IDX_W'(NUM_CH)) |=> resp_code == 2'd1);

    p_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op > 3'd4) |=> resp_code == 2'd1);

    p_period_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && cmd_data != '0 && cmd_data != mod && |cap_arm)
        |=> (resp_code == 2'd2 && $stable(mod)));

    p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mod);

    p_stop_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cmd_valid) |=> $stable(cnt));
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(
    .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_data(cmd_data), .cap_arm(cap_arm),
    .resp_valid(resp_valid), .resp_code(resp_code), .cnt(cnt_w),
    .mod(cur_mod), .run(run_now)
);

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;
    localparam int NUM_CH = 4;
    localparam int EXP    = 1;
    localparam int NVEC   = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_ch = '0;
    logic        cmd_inv = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [3:0]  cap_arm = '0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [31:0] resp_data;
    logic [3:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_edge_gen #(
        .NUM_CH(NUM_CH), .CH_IDX_W(4), .CNT_W(16), .RATE_W(32),
        .CLK_HZ(50_000_000), .PRESCALE_EXP(EXP), .MOD_RESET(255)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ch(cmd_ch), .cmd_inv(cmd_inv), .cmd_data(cmd_data),
        .cap_arm(cap_arm), .resp_valid(resp_valid), .resp_code(resp_code),
        .resp_data(resp_data), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  ch;
        logic        inv;
        logic [15:0] data;
        logic [3:0]  cap;
        logic [1:0]  code;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 4'd0,  1'b0, 16'd0,   4'b0000, 2'd1, 4'd1},  // R1 zero period
        '{3'd1, 4'd4,  1'b0, 16'd5,   4'b0000, 2'd1, 4'd2},  // R2 channel 4
        '{3'd1, 4'd15, 1'b0, 16'd5,   4'b0000, 2'd1, 4'd2},  // R2 channel 15
        '{3'd5, 4'd0,  1'b0, 16'd1,   4'b0000, 2'd1, 4'd12}, // R12 op 5
        '{3'd7, 4'd0,  1'b0, 16'd1,   4'b0000, 2'd1, 4'd12}, // R12 op 7
        '{3'd0, 4'd0,  1'b0, 16'd9,   4'b0001, 2'd2, 4'd8},  // R8 period busy
        '{3'd1, 4'd0,  1'b0, 16'd5,   4'b0010, 2'd2, 4'd8},  // R8 pair 0 busy
        '{3'd1, 4'd1,  1'b0, 16'd5,   4'b0010, 2'd2, 4'd8},  // R8 odd member busy
        '{3'd1, 4'd2,  1'b0, 16'd3,   4'b0010, 2'd0, 4'd8},  // R8 other pair ok
        '{3'd0, 4'd0,  1'b0, 16'd255, 4'b1111, 2'd0, 4'd8},  // R8 same period ok
        '{3'd3, 4'd0,  1'b0, 16'd0,   4'b0000, 2'd0, 4'd11}  // R11 stop ok
    };

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [3:0] ch, input logic inv,
                        input logic [15:0] data, input logic [3:0] cap,
                        output logic [1:0] code, output logic [31:0] rdata);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch; cmd_inv = inv;
        cmd_data = data; cap_arm = cap;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cap_arm = '0;
        code = resp_code; rdata = resp_data;
    endtask

    task automatic measure(input int ch, input int win, output int highs);
        highs = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) highs++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [1:0]  c;
        logic [31:0] rd;
        int          h;
        logic [3:0]  snap;
        bit          held;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 4'b0, "R7 reset outputs", int'(pwm_out), 0);
        check(resp_valid == 1'b0, "R7 reset resp_valid", int'(resp_valid), 0);

        for (int v = 0; v < NVEC; v++) begin
            send(VECS[v].op, VECS[v].ch, VECS[v].inv, VECS[v].data, VECS[v].cap, c, rd);
            checks++;
            if (c != VECS[v].code) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%0d expected=%0d", VECS[v].req, v, c, VECS[v].code);
            end
        end

        // R5/R9/R3: shadow writes become active through a period change
        send(3'd1, 4'd0, 1'b0, 16'd4, 4'b0, c, rd);
        send(3'd1, 4'd1, 1'b1, 16'd4, 4'b0, c, rd);
        send(3'd1, 4'd3, 1'b0, 16'd20, 4'b0, c, rd);
        send(3'd0, 4'd0, 1'b0, 16'd9, 4'b0, c, rd);
        check(c == 2'd0, "R5 period accept", int'(c), 0);
        idle(20);
        measure(0, 20, h); check(h == 8,  "R5 R9 ch0 duty 4", h, 8);
        measure(1, 20, h); check(h == 12, "R3 ch1 inverted", h, 12);
        measure(2, 20, h); check(h == 6,  "R9 ch2 duty 3", h, 6);
        measure(3, 20, h); check(h == 20, "R9 ch3 full", h, 20);

        // R6: duty writes wait for reload
        send(3'd1, 4'd0, 1'b0, 16'd7, 4'b0, c, rd);
        idle(20);
        measure(0, 20, h); check(h == 8, "R6 shadow only", h, 8);
        send(3'd2, 4'd0, 1'b0, 16'd0, 4'b0, c, rd);
        idle(20);
        measure(0, 20, h); check(h == 14, "R6 after reload", h, 14);

        // R9: zero duty
        send(3'd1, 4'd0, 1'b0, 16'd0, 4'b0, c, rd);
        send(3'd2, 4'd0, 1'b0, 16'd0, 4'b0, c, rd);
        idle(20);
        measure(0, 20, h); check(h == 0, "R9 zero duty", h, 0);

        // R4: shared period shrink
        send(3'd0, 4'd0, 1'b0, 16'd4, 4'b0, c, rd);
        idle(10);
        measure(1, 10, h); check(h == 0,  "R4 ch1 inverted full", h, 0);
        measure(2, 10, h); check(h == 6,  "R4 ch2", h, 6);
        measure(3, 10, h); check(h == 10, "R4 ch3", h, 10);

        // R11: stop holds outputs, start resumes
        send(3'd3, 4'd0, 1'b0, 16'd0, 4'b0, c, rd);
        idle(2);
        snap = pwm_out;
        held = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (pwm_out != snap) held = 1'b0;
        end
        check(held, "R11 stopped outputs hold", int'(held), 1);
        send(3'd3, 4'd0, 1'b0, 16'd1, 4'b0, c, rd);
        idle(10);
        measure(2, 10, h); check(h == 6, "R11 resumed", h, 6);

        // R10: tick rate
        send(3'd4, 4'd0, 1'b0, 16'd0, 4'b0, c, rd);
        check(c == 2'd0, "R10 rate code", int'(c), 0);
        check(rd == 32'd25_000_000, "R10 rate value", int'(rd), 25_000_000);

        // R1: rejected zero period changes nothing
        send(3'd0, 4'd0, 1'b0, 16'd0, 4'b0, c, rd);
        check(c == 2'd1, "R1 zero period code", int'(c), 1);
        idle(10);
        measure(2, 10, h); check(h == 6, "R1 ch2 unchanged", h, 6);

        // R5: counter restarts at zero on a new period
        send(3'd0, 4'd0, 1'b0, 16'd7, 4'b0, c, rd);
        measure(2, 6, h); check(h == 6, "R5 restart high run", h, 6);
        measure(2, 1, h); check(h == 0, "R5 restart falls at count 3", h, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule